// File: doc/BRIEF.md
# Interleaved DRAM Timing Sequencer

This block schedules one shared DRAM array between a display fetch engine and a CPU. A free-running phase counter splits every memory cycle into eight states. The first four states belong to video and the last four belong to the CPU. Both halves use the same strobe shape: row strobe, then the switch of the address multiplexer to column, then the column strobes. Each strobe window is decoded as the XOR or AND of taps of a square wave, where each tap is shifted one state further than the one before it. Every edge therefore falls on the same state in every cycle.

The CPU presents its address strobe and its byte strobes. The request is sampled once per cycle, when the counter steps from the last video state into the first CPU state. A request that arrives later waits a full cycle. Granted accesses see an acknowledge late in the CPU half, early enough to latch data before the column strobes rise. A granted access with neither byte strobe set still pulses the row strobe, which serves as a refresh. The display side samples its enable at the start of each cycle. When enabled, it reads both bytes and gets a shift-register load pulse at the end of its half.

Top module: `dram_slot_sequencer`

## Requirements
- R1: `phase` advances by one, modulo 8, every `STEP_DIV` (default 2) input clocks, and is 0 after reset.
- R2: `clk_half` toggles on every input clock. `cpu_clk` equals bit 0 of `phase`, so one CPU clock spans two states.
- R3: `ras_n` is low in states 1, 2 and 3 of every cycle. In states 5, 6 and 7 it is low only when the CPU holds the grant for that cycle.
- R4: `col_sel` is high (column address) in states 2, 3, 6 and 7, and low in states 0, 1, 4 and 5.
- R5: In state 3, `casu_n` and `casl_n` are both low if and only if `disp_en` was high at the step from state 7 into state 0 that opened the cycle.
- R6: `vid_load` is high only in state 3, and only when video was enabled for that cycle, as in R5.
- R7: The CPU gets the grant for a cycle only if `cpu_as` is high at the step from state 3 to state 4. A strobe raised during states 4 to 7 is served in the next cycle.
- R8: In state 7 of a granted cycle, `casu_n` is low exactly when `cpu_uds` is high, and `casl_n` is low exactly when `cpu_lds` is high. The column strobes are high in states 4 to 6.
- R9: A granted cycle with both byte strobes low still drives `ras_n` low in states 5 to 7, and keeps both column strobes high through the CPU half.
- R10: `cpu_ack` is high in states 6 and 7 of a granted cycle and low at all other times.
- R11: While reset is asserted and just after it: `phase` is 0, `ras_n`, `casu_n` and `casl_n` are high, and `col_sel`, `vid_load` and `cpu_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (30 MHz nominal) |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_as | input | 1 | CPU address strobe, active high |
| cpu_uds | input | 1 | CPU upper byte strobe, active high |
| cpu_lds | input | 1 | CPU lower byte strobe, active high |
| disp_en | input | 1 | Display enable; requests the video fetch |
| ras_n | output | 1 | DRAM row strobe, active low |
| casu_n | output | 1 | DRAM upper byte column strobe, active low |
| casl_n | output | 1 | DRAM lower byte column strobe, active low |
| col_sel | output | 1 | Address multiplexer select, 1 = column |
| vid_load | output | 1 | Video shift-register load pulse |
| cpu_ack | output | 1 | CPU data acknowledge |
| clk_half | output | 1 | Master clock divided by two |
| cpu_clk | output | 1 | CPU clock, one period per two states |
| phase | output | 3 | Current state of the memory cycle |

## Verification
The hardest case to reach is a CPU strobe that rises just after the decision point, in state 4. In that cycle the row strobe must stay high for the CPU half, and the access must be served one full cycle later. The bench follows `phase` at falling clock edges and raises `cpu_as` on the first sample that shows state 4. It then checks the rest of that cycle for no row strobe and no acknowledge, and checks the following cycle for a complete access. The refresh-only case is reached in the same way, with the address strobe held and both byte strobes low.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int unsigned NUM_STATES = 8;
  localparam int unsigned PHASE_W    = $clog2(NUM_STATES);
  localparam int unsigned HALF       = NUM_STATES / 2;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [NUM_STATES-1:0] taps_t;

  typedef struct packed {
    logic ras_n;
    logic casu_n;
    logic casl_n;
    logic col_sel;
    logic vid_load;
    logic cpu_ack;
  } dram_ctl_t;
endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_phase_gen.sv
module seq_phase_gen
  import dram_seq_pkg::*;
#(
  parameter int unsigned STEP_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  output logic   step,
  output phase_t phase,
  output taps_t  taps,
  output logic   clk_half
);
  localparam int unsigned PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  phase_t           cnt_q, cnt_d;
  logic             half_q, half_d;

  // next-state logic
  always_comb begin
    step   = (pre_q == PRE_LAST);
    pre_d  = step ? '0 : pre_q + 1'b1;
    cnt_d  = step ? cnt_q + 1'b1 : cnt_q;
    half_d = ~half_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      half_q <= half_d;
      if (step) cnt_q <= cnt_d;
    end
  end

  // tap k is the square wave (high in the video half) delayed by k states
  for (genvar k = 0; k < NUM_STATES; k++) begin : g_tap
    assign taps[k] = (phase_t'(cnt_q - phase_t'(k)) < phase_t'(HALF));
  end

  assign phase    = cnt_q;
  assign clk_half = half_q;

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == phase_t'($past(cnt_q) + 1'b1))); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/seq_slot_arbiter.sv
module seq_slot_arbiter
  import dram_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  phase_t phase,
  input  logic   cpu_as,
  input  logic   disp_en,
  output logic   cpu_grant,
  output logic   vid_grant
);
  localparam phase_t LAST_VID = phase_t'(HALF - 1);
  localparam phase_t LAST_CPU = phase_t'(NUM_STATES - 1);

  logic cpu_q, cpu_d, vid_q, vid_d;
  logic enter_cpu, enter_vid;

  always_comb begin
    enter_cpu = step && (phase == LAST_VID);
    enter_vid = step && (phase == LAST_CPU);
    cpu_d = cpu_q;
    vid_d = vid_q;
    if (enter_cpu) cpu_d = cpu_as;
    if (enter_vid) begin
      cpu_d = 1'b0;
      vid_d = disp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
      vid_q <= 1'b0;
    end else begin
      if (enter_cpu || enter_vid) cpu_q <= cpu_d;
      if (enter_vid)              vid_q <= vid_d;
    end
  end

  assign cpu_grant = cpu_q;
  assign vid_grant = vid_q;

  AST_GRANT_ONLY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != LAST_VID && phase != LAST_CPU) |=> $stable(cpu_q)); // R7
  AST_GRANT_VOID_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase < phase_t'(HALF)) |-> !cpu_q); // R7
endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
  import dram_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  taps_t     taps,
  input  logic      cpu_grant,
  input  logic      vid_grant,
  input  logic      cpu_uds,
  input  logic      cpu_lds,
  output dram_ctl_t ctl
);
  logic in_video, ras_win, col_win, cas_win, load_win, ack_win;
  logic ras_act, casu_act, casl_act;
  wire  unused_taps = &{1'b0, taps[1], taps[7]};

  always_comb begin
    in_video = taps[0];
    ras_win  = taps[0] ^ taps[5];   // states 1-3 and 5-7
    col_win  = taps[2] ^ taps[4];   // states 2,3 and 6,7
    cas_win  = taps[3] ^ taps[4];   // states 3 and 7
    load_win = taps[3] & ~taps[4];  // state 3
    ack_win  = taps[4] & taps[6];   // states 6,7

    ras_act  = ras_win & (in_video | cpu_grant);
    casu_act = cas_win & (in_video ? vid_grant : (cpu_grant & cpu_uds));
    casl_act = cas_win & (in_video ? vid_grant : (cpu_grant & cpu_lds));

    ctl.ras_n    = ~ras_act;
    ctl.casu_n   = ~casu_act;
    ctl.casl_n   = ~casl_act;
    ctl.col_sel  = col_win;
    ctl.vid_load = load_win & vid_grant;
    ctl.cpu_ack  = ack_win & cpu_grant;
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.casu_n || !ctl.casl_n) |-> !ctl.ras_n); // R8
  AST_CAS_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.casu_n || !ctl.casl_n) |-> ctl.col_sel); // R4
  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cpu_ack |-> (cpu_grant && !in_video)); // R10
  AST_LOAD_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.vid_load |-> (vid_grant && in_video)); // R6
endmodule

// File: rtl/dram_slot_sequencer.sv
module dram_slot_sequencer
  import dram_seq_pkg::*;
#(
  parameter int unsigned STEP_DIV = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       cpu_as,
  input  logic       cpu_uds,
  input  logic       cpu_lds,
  input  logic       disp_en,
  output logic       ras_n,
  output logic       casu_n,
  output logic       casl_n,
  output logic       col_sel,
  output logic       vid_load,
  output logic       cpu_ack,
  output logic       clk_half,
  output logic       cpu_clk,
  output logic [2:0] phase
);
  logic      rst_n, step, cpu_grant, vid_grant;
  phase_t    phase_w;
  taps_t     taps;
  dram_ctl_t ctl;

  seq_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .srst_n(rst_n));

  seq_phase_gen #(.STEP_DIV(STEP_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(step), .phase(phase_w),
    .taps(taps), .clk_half(clk_half));

  seq_slot_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .step(step), .phase(phase_w),
    .cpu_as(cpu_as), .disp_en(disp_en),
    .cpu_grant(cpu_grant), .vid_grant(vid_grant));

  seq_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .taps(taps), .cpu_grant(cpu_grant),
    .vid_grant(vid_grant), .cpu_uds(cpu_uds), .cpu_lds(cpu_lds), .ctl(ctl));

  assign ras_n    = ctl.ras_n;
  assign casu_n   = ctl.casu_n;
  assign casl_n   = ctl.casl_n;
  assign col_sel  = ctl.col_sel;
  assign vid_load = ctl.vid_load;
  assign cpu_ack  = ctl.cpu_ack;
  assign cpu_clk  = phase_w[0];
  assign phase    = phase_w;

  AST_RAS_GAP_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w == 3'd0 || phase_w == 3'd4) |-> ras_n); // R3
endmodule

// File: tb/dram_slot_sequencer_tb.sv
module dram_slot_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic cpu_as = 1'b0, cpu_uds = 1'b0, cpu_lds = 1'b0, disp_en = 1'b0;
  logic ras_n, casu_n, casl_n, col_sel, vid_load, cpu_ack, clk_half, cpu_clk;
  logic [2:0] phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_slot_sequencer u_dut (
    .clk(clk), .arst_n(arst_n), .cpu_as(cpu_as), .cpu_uds(cpu_uds),
    .cpu_lds(cpu_lds), .disp_en(disp_en), .ras_n(ras_n), .casu_n(casu_n),
    .casl_n(casl_n), .col_sel(col_sel), .vid_load(vid_load),
    .cpu_ack(cpu_ack), .clk_half(clk_half), .cpu_clk(cpu_clk), .phase(phase));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_phase(input int s);
    @(negedge clk);
    while (phase != 3'(s)) @(negedge clk);
  endtask

  // checks one state against the expected picture; g = CPU grant, v = video
  task automatic check_state(input int s, input bit v, input bit g,
                             input bit u, input bit l, input string tag);
    bit exp_ras, exp_col, exp_cu, exp_cl, exp_ld, exp_ack;
    exp_ras = (s >= 1 && s <= 3) || (g && s >= 5);
    exp_col = (s == 2) || (s == 3) || (s == 6) || (s == 7);
    exp_cu  = (v && s == 3) || (g && u && s == 7);
    exp_cl  = (v && s == 3) || (g && l && s == 7);
    exp_ld  = v && s == 3;
    exp_ack = g && (s == 6 || s == 7);
    check(ras_n == !exp_ras, {tag, " R3"}, $sformatf("ras_n s%0d", s), ras_n, !exp_ras);
    check(col_sel == exp_col, {tag, " R4"}, $sformatf("col_sel s%0d", s), col_sel, exp_col);
    check(casu_n == !exp_cu, {tag, " R5/R8"}, $sformatf("casu_n s%0d", s), casu_n, !exp_cu);
    check(casl_n == !exp_cl, {tag, " R5/R8"}, $sformatf("casl_n s%0d", s), casl_n, !exp_cl);
    check(vid_load == exp_ld, {tag, " R6"}, $sformatf("vid_load s%0d", s), vid_load, exp_ld);
    check(cpu_ack == exp_ack, {tag, " R10"}, $sformatf("cpu_ack s%0d", s), cpu_ack, exp_ack);
  endtask

  task automatic check_cycle(input bit v, input bit g, input bit u,
                             input bit l, input string tag);
    for (int s = 0; s < 8; s++) begin
      wait_phase(s);
      check_state(s, v, g, u, l, tag);
    end
  endtask

  // drive inputs mid-cycle so that both sample points see them
  task automatic setup(input bit v, input bit as, input bit u, input bit l);
    wait_phase(1);
    disp_en = v; cpu_as = as; cpu_uds = u; cpu_lds = l;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(phase == 3'd0, "R11", "phase in reset", phase, 0);
    check(ras_n && casu_n && casl_n, "R11", "strobes in reset",
          {ras_n, casu_n, casl_n}, 7);
    check(!col_sel && !vid_load && !cpu_ack, "R11", "ctl in reset",
          {col_sel, vid_load, cpu_ack}, 0);
    arst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(phase == 3'd0, "R11", "phase after release", phase, 0);
  endtask

  task automatic t_step_timing;
    int cnt_clk;
    int prev;
    wait_phase(2);
    prev = phase;
    cnt_clk = 0;
    for (int i = 0; i < 16; i++) begin
      bit h0;
      h0 = clk_half;
      @(negedge clk);
      cnt_clk++;
      check(clk_half != h0, "R2", "clk_half toggle", clk_half, !h0);
      check(cpu_clk == phase[0], "R2", "cpu_clk vs phase", cpu_clk, phase[0]);
      if (phase != 3'(prev)) begin
        check(cnt_clk == 2, "R1", "clocks per state", cnt_clk, 2);
        check(phase == 3'(prev + 1), "R1", "phase increment", phase, (prev + 1) % 8);
        prev = phase;
        cnt_clk = 0;
      end
    end
  endtask

  task automatic t_idle;
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    check_cycle(1'b0, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  task automatic t_video_only;
    setup(1'b1, 1'b0, 1'b0, 1'b0);
    check_cycle(1'b1, 1'b0, 1'b0, 1'b0, "video");
  endtask

  task automatic t_cpu_word;
    setup(1'b1, 1'b1, 1'b1, 1'b1);
    check_cycle(1'b1, 1'b1, 1'b1, 1'b1, "word R7");
    cpu_as = 1'b0;
  endtask

  task automatic t_cpu_upper;
    setup(1'b0, 1'b1, 1'b1, 1'b0);
    check_cycle(1'b0, 1'b1, 1'b1, 1'b0, "upper R8");
    cpu_as = 1'b0;
  endtask

  task automatic t_cpu_lower;
    setup(1'b1, 1'b1, 1'b0, 1'b1);
    check_cycle(1'b1, 1'b1, 1'b0, 1'b1, "lower R8");
    cpu_as = 1'b0;
  endtask

  task automatic t_refresh;
    setup(1'b0, 1'b1, 1'b0, 1'b0);
    check_cycle(1'b0, 1'b1, 1'b0, 1'b0, "refresh R9");
    cpu_as = 1'b0;
  endtask

  task automatic t_late_request;
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    wait_phase(4);
    cpu_as = 1'b1; cpu_uds = 1'b1; cpu_lds = 1'b1;
    check_state(4, 1'b0, 1'b0, 1'b1, 1'b1, "late R7");
    for (int s = 5; s < 8; s++) begin
      wait_phase(s);
      check_state(s, 1'b0, 1'b0, 1'b1, 1'b1, "late R7");
    end
    check_cycle(1'b0, 1'b1, 1'b1, 1'b1, "deferred R7");
    cpu_as = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_step_timing();
    t_idle();
    t_video_only();
    t_cpu_word();
    t_cpu_upper();
    t_cpu_lower();
    t_refresh();
    t_late_request();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule